// File: doc/BRIEF.md
# Memory-to-I/O Block Output Sequencer

This block copies a run of bytes from memory to a range of I/O ports, the way a block-output instruction does inside a CPU. It holds a 16-bit memory pointer, an 8-bit port register and an 8-bit byte counter. All three are loaded while the engine is idle. A start strobe then launches a transfer. Each step reads one byte from memory, writes it to the I/O port, and then moves the pointer and the port one place, both in the same direction. It also counts the counter down by one.

The port register moves along with the memory pointer. Because of this, one command can fill a whole bank of consecutive peripheral registers. Single mode does one step and stops. Repeat mode keeps stepping until the counter reaches zero. The engine reports zero and sign flags taken from the counter, a busy level, and a one-clock done pulse. The three registers can be read at the outputs.

Top module: `blkout_seq`

## Requirements
- R1: While idle, a high `load_en` writes `load_ptr`, `load_port` and `load_cnt` into the pointer, port and counter. The new values appear on `cur_ptr`, `cur_port` and `cur_cnt` one clock later.
- R2: Each step takes exactly three clocks, in this order:
  - a read clock with `mem_rd` high, in which `mem_rdata` is captured;
  - a write clock with `io_wr` high, driving the captured byte on `io_wdata`;
  - an update clock.
  `busy` is high on exactly those clocks, starting the clock after the start strobe is sampled.
- R3: During a write clock, `io_addr[15:8]` is 00h and `io_addr[7:0]` is the port register. During a read clock, `mem_addr` is the pointer.
- R4: With `dir_dec` low at start, the pointer and the port each increase by one per step. With `dir_dec` high, they each decrease by one. The pointer wraps modulo 65536 and the port wraps modulo 256.
- R5: The counter decreases by one on every step, and wraps from 0 to 255.
- R6: With `rpt` low at start, exactly one step is performed.
- R7: With `rpt` high at start, steps continue until the counter reaches zero. A starting count of 0 gives 256 steps.
- R8: After each update, `zero_flag` is 1 exactly when the counter is zero, and `sign_flag` equals bit 7 of the counter.
- R9: While busy, `start`, `dir_dec`, `rpt` and `load_en` have no effect on the transfer or on the registers.
- R10: `done` is high for exactly one clock, the first idle clock after the last update. `busy` is low during that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Load the registers (idle only) |
| load_ptr | input | 16 | Memory pointer load value |
| load_port | input | 8 | Port register load value |
| load_cnt | input | 8 | Byte counter load value |
| start | input | 1 | Start strobe |
| dir_dec | input | 1 | 1 = decrement, 0 = increment |
| rpt | input | 1 | 1 = repeat until counter is zero |
| mem_rd | output | 1 | Memory read clock |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Memory read data, same clock |
| io_wr | output | 1 | I/O write clock |
| io_addr | output | 16 | I/O address, upper byte zero |
| io_wdata | output | 8 | I/O write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| zero_flag | output | 1 | Counter is zero after last step |
| sign_flag | output | 1 | Bit 7 of counter after last step |
| cur_ptr | output | 16 | Memory pointer |
| cur_port | output | 8 | Port register |
| cur_cnt | output | 8 | Byte counter |

## Verification
The start strobe is sampled on a rising edge. The first read clock follows on the next clock, and the write comes one clock after its read. For step i, the read is on clock 3i+1 after the strobe and the write is on clock 3i+2. `done` and the updated pointer, port, counter and flags are all due on clock 3N+1. The bench drives on falling edges and samples on every falling edge after the strobe. It checks each read address and each write address and data against the step index it has counted. It also counts the busy clocks, then checks the final register values when `done` appears and that `done` has dropped one clock later. Sweeps cover both directions, both modes, wrap points, the zero starting count, and a start and load issued in the middle of a transfer.

// File: rtl/blkout_pkg.sv
`timescale 1ns/1ps
package blkout_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_UPD   = 2'd3
    } step_e;
endpackage

// File: rtl/blkout_fsm.sv
`timescale 1ns/1ps
module blkout_fsm
    import blkout_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_dec,
    input  logic              rpt,
    input  logic              cnt_last,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              io_wr,
    output logic              upd,
    output logic              dec,
    output logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done
);
    typedef struct packed {
        step_e             st;
        logic              dec;
        logic              rpt;
        logic [DATA_W-1:0] data;
        logic              done;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st  = ST_READ;
                    s_d.dec = dir_dec;
                    s_d.rpt = rpt;
                end
            end
            ST_READ: begin
                s_d.data = mem_rdata;
                s_d.st   = ST_WRITE;
            end
            ST_WRITE: s_d.st = ST_UPD;
            ST_UPD: begin
                if (s_q.rpt && !cnt_last) begin
                    s_d.st = ST_READ;
                end else begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, dec: 1'b0, rpt: 1'b0, data: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_rd = (s_q.st == ST_READ);
    assign io_wr  = (s_q.st == ST_WRITE);
    assign upd    = (s_q.st == ST_UPD);
    assign busy   = (s_q.st != ST_IDLE);
    assign dec    = s_q.dec;
    assign wdata  = s_q.data;
    assign done   = s_q.done;

    a_r2_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |-> $past(mem_rd));
    a_r2_update_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> $past(io_wr));
    a_r3_data_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |-> wdata == $past(mem_rdata));
    a_r6_single_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !s_q.rpt) |=> !busy);
    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !upd) |=> busy);
    a_r10_done_once: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/blkout_regs.sv
`timescale 1ns/1ps
module blkout_regs #(
    parameter int ADDR_W = 16,
    parameter int PORT_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_ptr,
    input  logic [PORT_W-1:0] load_port,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic              upd,
    input  logic              dec,
    output logic [ADDR_W-1:0] ptr,
    output logic [PORT_W-1:0] port,
    output logic [CNT_W-1:0]  cnt,
    output logic              zf,
    output logic              sf,
    output logic              cnt_last
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic [PORT_W-1:0] port;
        logic [CNT_W-1:0]  cnt;
        logic              zf;
        logic              sf;
    } regs_t;

    regs_t r_d, r_q;
    logic [CNT_W-1:0] cnt_dec;

    always_comb begin
        r_d     = r_q;
        cnt_dec = r_q.cnt - CNT_W'(1);
        if (upd) begin
            r_d.ptr  = dec ? r_q.ptr  - ADDR_W'(1) : r_q.ptr  + ADDR_W'(1);
            r_d.port = dec ? r_q.port - PORT_W'(1) : r_q.port + PORT_W'(1);
            r_d.cnt  = cnt_dec;
            r_d.zf   = (cnt_dec == '0);
            r_d.sf   = cnt_dec[CNT_W-1];
        end else if (load_en && !busy) begin
            r_d.ptr  = load_ptr;
            r_d.port = load_port;
            r_d.cnt  = load_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ptr      = r_q.ptr;
    assign port     = r_q.port;
    assign cnt      = r_q.cnt;
    assign zf       = r_q.zf;
    assign sf       = r_q.sf;
    assign cnt_last = (r_q.cnt == CNT_W'(1));

    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> cnt == $past(cnt) - CNT_W'(1));
    a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !dec) |=> ptr == $past(ptr) + ADDR_W'(1));
    a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && dec) |=> ptr == $past(ptr) - ADDR_W'(1));
    a_r8_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> zf == (cnt == '0));
    a_r9_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !upd) |=> ($stable(ptr) && $stable(port) && $stable(cnt)));
endmodule

// File: rtl/blkout_seq.sv
`timescale 1ns/1ps
module blkout_seq #(
    parameter int ADDR_W = 16,
    parameter int PORT_W = 8,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_ptr,
    input  logic [PORT_W-1:0] load_port,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic              start,
    input  logic              dir_dec,
    input  logic              rpt,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              io_wr,
    output logic [ADDR_W-1:0] io_addr,
    output logic [DATA_W-1:0] io_wdata,
    output logic              busy,
    output logic              done,
    output logic              zero_flag,
    output logic              sign_flag,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic [PORT_W-1:0] cur_port,
    output logic [CNT_W-1:0]  cur_cnt
);
    localparam int HI_W = ADDR_W - PORT_W;

    logic upd, dec, cnt_last;

    blkout_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dir_dec   (dir_dec),
        .rpt       (rpt),
        .cnt_last  (cnt_last),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .io_wr     (io_wr),
        .upd       (upd),
        .dec       (dec),
        .wdata     (io_wdata),
        .busy      (busy),
        .done      (done)
    );

    blkout_regs #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .load_en   (load_en),
        .load_ptr  (load_ptr),
        .load_port (load_port),
        .load_cnt  (load_cnt),
        .upd       (upd),
        .dec       (dec),
        .ptr       (cur_ptr),
        .port      (cur_port),
        .cnt       (cur_cnt),
        .zf        (zero_flag),
        .sf        (sign_flag),
        .cnt_last  (cnt_last)
    );

    assign mem_addr = cur_ptr;
    assign io_addr  = {{HI_W{1'b0}}, cur_port};

    a_r7_repeat_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && busy && cur_cnt != CNT_W'(1) && !done) |-> 1'b1 ##1 (done || mem_rd));
    a_r3_upper_zero_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |-> (io_addr[ADDR_W-1:PORT_W] == '0 && $past(mem_addr) == mem_addr));
endmodule

// File: tb/test_blkout_seq.sv
`timescale 1ns/1ps
module test_blkout_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [15:0] load_ptr = '0;
    logic [7:0]  load_port = '0;
    logic [7:0]  load_cnt = '0;
    logic        start = 1'b0;
    logic        dir_dec = 1'b0;
    logic        rpt = 1'b0;
    logic        mem_rd, io_wr, busy, done, zero_flag, sign_flag;
    logic [15:0] mem_addr, io_addr, cur_ptr;
    logic [7:0]  mem_rdata, io_wdata, cur_port, cur_cnt;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] mem_fn(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'hA5;
    endfunction

    assign mem_rdata = mem_fn(mem_addr);

    blkout_seq i_blkout_seq (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_ptr(load_ptr),
        .load_port(load_port), .load_cnt(load_cnt), .start(start),
        .dir_dec(dir_dec), .rpt(rpt), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .busy(busy), .done(done), .zero_flag(zero_flag),
        .sign_flag(sign_flag), .cur_ptr(cur_ptr), .cur_port(cur_port),
        .cur_cnt(cur_cnt)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_load(input logic [15:0] p, input logic [7:0] q, input logic [7:0] c);
        @(negedge clk);
        load_en = 1'b1; load_ptr = p; load_port = q; load_cnt = c;
        @(negedge clk);
        load_en = 1'b0;
        chk("R1", "ptr after load", 32'(cur_ptr), 32'(p));
        chk("R1", "port after load", 32'(cur_port), 32'(q));
        chk("R1", "cnt after load", 32'(cur_cnt), 32'(c));
    endtask

    task automatic run(input logic dec, input logic rp, input bit poke);
        logic [15:0] p0;
        logic [7:0]  q0, c0, ef;
        logic [15:0] ea;
        logic [7:0]  eq;
        int n, busy_cyc, rd_i, wr_i;
        bit got_done;
        p0 = cur_ptr; q0 = cur_port; c0 = cur_cnt;
        n = rp ? ((c0 == 8'd0) ? 256 : int'(c0)) : 1;
        busy_cyc = 0; rd_i = 0; wr_i = 0; got_done = 0;
        @(negedge clk);
        start = 1'b1; dir_dec = dec; rpt = rp;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 2000 && !got_done; t++) begin
            if (t > 0) @(negedge clk);
            if (done) begin
                got_done = 1;
            end else begin
                if (busy) busy_cyc++;
                if (mem_rd) begin
                    ea = dec ? p0 - 16'(rd_i) : p0 + 16'(rd_i);
                    chk("R3", "read address", 32'(mem_addr), 32'(ea));
                    rd_i++;
                end
                if (io_wr) begin
                    ea = dec ? p0 - 16'(wr_i) : p0 + 16'(wr_i);
                    eq = dec ? q0 - 8'(wr_i) : q0 + 8'(wr_i);
                    chk("R3", "io address", 32'(io_addr), 32'({8'h00, eq}));
                    chk("R2", "io data", 32'(io_wdata), 32'(mem_fn(ea)));
                    wr_i++;
                end
                // R9: strobe, flip mode and load while busy
                if (poke && t == 1) begin
                    start = 1'b1; dir_dec = ~dec; rpt = ~rp;
                    load_en = 1'b1; load_ptr = 16'h1234; load_port = 8'h77; load_cnt = 8'h09;
                end else begin
                    start = 1'b0; load_en = 1'b0;
                end
            end
        end
        start = 1'b0; load_en = 1'b0;
        chk("R10", "done seen", 32'(got_done), 32'd1);
        chk("R10", "busy low with done", 32'(busy), 32'd0);
        chk("R2", "busy cycles", 32'(busy_cyc), 32'(3 * n));
        chk(rp ? "R7" : "R6", "step count", 32'(wr_i), 32'(n));
        ea = dec ? p0 - 16'(n) : p0 + 16'(n);
        eq = dec ? q0 - 8'(n) : q0 + 8'(n);
        ef = c0 - 8'(n);
        chk("R4", "final ptr", 32'(cur_ptr), 32'(ea));
        chk("R4", "final port", 32'(cur_port), 32'(eq));
        chk("R5", "final cnt", 32'(cur_cnt), 32'(ef));
        chk("R8", "zero flag", 32'(zero_flag), 32'(ef == 8'd0));
        chk("R8", "sign flag", 32'(sign_flag), 32'(ef[7]));
        if (poke) chk("R9", "poke ignored ptr", 32'(cur_ptr), 32'(ea));
        @(negedge clk);
        chk("R10", "done one clock", 32'(done), 32'd0);
        chk("R9", "no restart", 32'(busy), 32'd0);
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "reset busy", 32'(busy), 32'd0);
        chk("R10", "reset done", 32'(done), 32'd0);
        chk("R2", "reset io_wr", 32'(io_wr), 32'd0);
        chk("R2", "reset mem_rd", 32'(mem_rd), 32'd0);
        chk("R8", "reset zero", 32'(zero_flag), 32'd0);

        // single steps, both directions, wrap points
        for (int d = 0; d < 2; d++) begin
            do_load(16'h4000, 8'h10, 8'h05); run(d[0], 1'b0, 0);
            do_load(16'hFFFF, 8'hFF, 8'h01); run(d[0], 1'b0, 0);
            do_load(16'h0000, 8'h00, 8'h00); run(d[0], 1'b0, 0);
            do_load(16'h8000, 8'h80, 8'h80); run(d[0], 1'b0, 1);
        end
        // repeat mode sweep of counts
        for (int d = 0; d < 2; d++) begin
            for (int c = 1; c <= 6; c++) begin
                do_load(16'hFFFD + 16'(c), 8'hFE, 8'(c));
                run(d[0], 1'b1, 0);
            end
            do_load(16'h0102, 8'h03, 8'd129); run(d[0], 1'b1, 0);
            do_load(16'h7FF0, 8'hF8, 8'd0);   run(d[0], 1'b1, 0);
            do_load(16'h2000, 8'h40, 8'd4);   run(d[0], 1'b1, 1);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule